// File: doc/BRIEF.md
# Jump Instruction Byte Decoder

This block sits in an instruction front end and turns a stream of instruction bytes into decoded unconditional-jump records. Bytes arrive one per handshake on a valid/ready input. The first byte of each instruction is the opcode. Depending on that opcode and the effective operand size, the block then takes one ModRM byte or a run of immediate bytes. Once the instruction is complete it presents a single record on the output.

The record gives the jump class and the effective operand size. It carries the displacement or far-pointer offset, widened to the output width: sign-extended for relative forms and zero-extended for far offsets. It also carries the 16-bit selector of a direct far jump, the ModRM fields of the indirect forms, an invalid flag, and the number of bytes consumed, so that a later stage can form the next-instruction address. The effective operand size is the default size XOR an override input, sampled when the opcode byte is taken.

While a record waits to be accepted, the byte input is held off. Address-mode bytes that follow a ModRM (SIB, memory displacement), effective-address work and the jump itself belong to later stages.

Top module: `jmp_byte_decoder`

## Requirements
- R1: After reset `in_ready` is 1 and `rec_valid` is 0.
- R2: Opcode 0xEB takes one immediate byte. It yields class 1 (short relative), length 2, and `rec_disp` is that byte sign-extended to DISP_W bits.
- R3: Opcode 0xE9 yields class 2 (near relative). At operand size 16 it takes 2 immediate bytes and reports length 3. At operand size 32 it takes 4 immediate bytes and reports length 5. In both cases the value is assembled little-endian and sign-extended to DISP_W bits.
- R4: The effective operand size is 32 when `def_op32` XOR `osz_ovr` is 1, and 16 otherwise. It is sampled with the opcode byte and reported on `rec_op32`. Changing the inputs after the opcode byte has no effect on that instruction.
- R5: Opcode 0xFF followed by a ModRM byte with reg field (bits 5:3) equal to 4 yields class 3 (near indirect) and length 2, for any mod value. The record reports mod (bits 7:6), reg and rm (bits 2:0).
- R6: Opcode 0xFF with ModRM reg field 5 and mod not equal to 3 yields class 5 (far indirect), length 2, with `rec_bad` at 0.
- R7: Opcode 0xEA yields class 4 (far direct). The offset bytes come first, little-endian, followed by a 2-byte selector. At size 16 the offset is 2 bytes, zero-extended, and the length is 5. At size 32 the offset is 4 bytes and the length is 7.
- R8: The following set `rec_bad` to 1 with class 0: opcode 0xFF with a reg field other than 4 or 5; opcode 0xFF with reg 5 and mod 3 (length 2); any other opcode (length 1, no further bytes consumed).
- R9: While `rec_valid` is 1 and `rec_ready` is 0, `in_ready` stays 0, no input byte is consumed, and the record holds steady.
- R10: A byte is consumed only on a cycle with `in_valid` and `in_ready` both 1. Idle cycles between the bytes of an instruction do not change the record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| def_op32 | input | 1 | Default operand size is 32 bits |
| osz_ovr | input | 1 | Operand-size override active |
| in_valid | input | 1 | Input byte valid |
| in_byte | input | 8 | Instruction byte |
| in_ready | output | 1 | Decoder can take a byte |
| rec_valid | output | 1 | Decoded record valid |
| rec_ready | input | 1 | Downstream accepts the record |
| rec_cls | output | 3 | Jump class (0 none, 1 short rel, 2 near rel, 3 near ind, 4 far direct, 5 far ind) |
| rec_op32 | output | 1 | Effective operand size is 32 |
| rec_disp | output | DISP_W | Sign-extended displacement or zero-extended far offset |
| rec_sel | output | 16 | Selector of a direct far jump |
| rec_mod | output | 2 | ModRM mod field |
| rec_reg | output | 3 | ModRM reg field |
| rec_rm | output | 3 | ModRM rm field |
| rec_bad | output | 1 | Invalid opcode or ModRM combination |
| rec_len | output | LEN_W | Instruction length in bytes |

## Verification
The bench builds the decoder twice on the same stimulus. The first instance uses the default DISP_W of 32 and MAX_IMM of 6, which exercises every immediate length up to the 6-byte far pointer. The second uses a DISP_W of 40, where sign extension of short and near displacements must fill bits above bit 31 rather than stop at the 32-bit boundary. Both instances share the checker, so its length, sign and hold properties are evaluated at both widths.

// File: rtl/jmpdec_pkg.sv
package jmpdec_pkg;
   typedef enum logic [2:0] {
      JC_NONE     = 3'd0,
      JC_SHORT    = 3'd1,
      JC_NEAR_REL = 3'd2,
      JC_NEAR_IND = 3'd3,
      JC_FAR_DIR  = 3'd4,
      JC_FAR_IND  = 3'd5
   } jcls_t;

   typedef enum logic [1:0] {
      ST_OPC   = 2'd0,
      ST_MODRM = 2'd1,
      ST_IMM   = 2'd2,
      ST_OUT   = 2'd3
   } dstate_t;

   localparam logic [7:0] OPC_JSHORT = 8'hEB;
   localparam logic [7:0] OPC_JNEAR  = 8'hE9;
   localparam logic [7:0] OPC_JFAR   = 8'hEA;
   localparam logic [7:0] OPC_GRP    = 8'hFF;
endpackage

// File: rtl/jmpdec_classify.sv
module jmpdec_classify
   import jmpdec_pkg::*;
#(
   parameter int LEN_W = 3
) (
   input  logic [7:0]       opcode,
   input  logic             op32,
   output jcls_t            cls,
   output logic             need_modrm,
   output logic [LEN_W-1:0] imm_len
);
   always_comb begin
      cls        = JC_NONE;
      need_modrm = 1'b0;
      imm_len    = '0;
      unique case (opcode)
         OPC_JSHORT: begin
            cls     = JC_SHORT;
            imm_len = LEN_W'(1);
         end
         OPC_JNEAR: begin
            cls     = JC_NEAR_REL;
            imm_len = op32 ? LEN_W'(4) : LEN_W'(2);
         end
         OPC_JFAR: begin
            cls     = JC_FAR_DIR;
            imm_len = op32 ? LEN_W'(6) : LEN_W'(4);
         end
         OPC_GRP:  need_modrm = 1'b1;
         default:  ;
      endcase
   end
endmodule

// File: rtl/jmpdec_modrm_sel.sv
module jmpdec_modrm_sel
   import jmpdec_pkg::*;
(
   input  logic [7:0] modrm,
   output jcls_t      cls,
   output logic       bad
);
   logic [1:0] mode;
   logic [2:0] sub;
   assign mode = modrm[7:6];
   assign sub  = modrm[5:3];

   always_comb begin
      cls = JC_NONE;
      bad = 1'b1;
      if (sub == 3'd4) begin
         cls = JC_NEAR_IND;
         bad = 1'b0;
      end else if (sub == 3'd5 && mode != 2'd3) begin
         cls = JC_FAR_IND;
         bad = 1'b0;
      end
   end
endmodule

// File: rtl/jmpdec_imm_buf.sv
module jmpdec_imm_buf
   import jmpdec_pkg::*;
#(
   parameter int DISP_W  = 32,
   parameter int MAX_IMM = 6,
   localparam int IDX_W  = $clog2(MAX_IMM)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [7:0]        wr_byte,
   input  jcls_t             cls,
   input  logic              op32,
   output logic [DISP_W-1:0] disp,
   output logic [15:0]       sel
);
   logic [8*MAX_IMM-1:0] imm_flat;

   for (genvar g = 0; g < MAX_IMM; g++) begin : g_lane
      logic [7:0] lane_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                 lane_q <= '0;
         else if (clr)                               lane_q <= '0;
         else if (wr_en && wr_idx == IDX_W'(g))      lane_q <= wr_byte;
      end
      assign imm_flat[8*g +: 8] = lane_q;
   end

   always_comb begin
      disp = '0;
      sel  = '0;
      unique case (cls)
         JC_SHORT:    disp = DISP_W'(signed'(imm_flat[7:0]));
         JC_NEAR_REL: disp = op32 ? DISP_W'(signed'(imm_flat[31:0]))
                                  : DISP_W'(signed'(imm_flat[15:0]));
         JC_FAR_DIR: begin
            if (op32) begin
               disp = DISP_W'(imm_flat[31:0]);
               sel  = imm_flat[47:32];
            end else begin
               disp = DISP_W'(imm_flat[15:0]);
               sel  = imm_flat[31:16];
            end
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/jmp_byte_decoder.sv
module jmp_byte_decoder
   import jmpdec_pkg::*;
#(
   parameter int DISP_W  = 32,
   parameter int MAX_IMM = 6,
   localparam int LEN_W  = $clog2(MAX_IMM + 2),
   localparam int IDX_W  = $clog2(MAX_IMM)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              def_op32,
   input  logic              osz_ovr,
   input  logic              in_valid,
   input  logic [7:0]        in_byte,
   output logic              in_ready,
   output logic              rec_valid,
   input  logic              rec_ready,
   output logic [2:0]        rec_cls,
   output logic              rec_op32,
   output logic [DISP_W-1:0] rec_disp,
   output logic [15:0]       rec_sel,
   output logic [1:0]        rec_mod,
   output logic [2:0]        rec_reg,
   output logic [2:0]        rec_rm,
   output logic              rec_bad,
   output logic [LEN_W-1:0]  rec_len
);
   if (DISP_W < 32) begin : g_chk_disp
      $error("DISP_W must be at least 32");
   end
   if (MAX_IMM < 6) begin : g_chk_imm
      $error("MAX_IMM must hold a 6-byte far pointer");
   end

   dstate_t          state_q;
   jcls_t            cls_q;
   logic             op32_q, bad_q;
   logic [7:0]       modrm_q;
   logic [LEN_W-1:0] len_q, imm_len_q;
   logic [IDX_W-1:0] cnt_q;

   logic             take, op32_now;
   jcls_t            opc_cls, mrm_cls;
   logic             need_modrm, mrm_bad;
   logic [LEN_W-1:0] opc_imm_len;

   assign in_ready  = (state_q != ST_OUT);
   assign rec_valid = (state_q == ST_OUT);
   assign take      = in_valid && in_ready;
   assign op32_now  = def_op32 ^ osz_ovr;

   jmpdec_classify #(.LEN_W(LEN_W)) u_classify (
      .opcode     (in_byte),
      .op32       (op32_now),
      .cls        (opc_cls),
      .need_modrm (need_modrm),
      .imm_len    (opc_imm_len)
   );

   jmpdec_modrm_sel u_modrm (
      .modrm (in_byte),
      .cls   (mrm_cls),
      .bad   (mrm_bad)
   );

   jmpdec_imm_buf #(.DISP_W(DISP_W), .MAX_IMM(MAX_IMM)) u_imm (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (take && state_q == ST_OPC),
      .wr_en   (take && state_q == ST_IMM),
      .wr_idx  (cnt_q),
      .wr_byte (in_byte),
      .cls     (cls_q),
      .op32    (op32_q),
      .disp    (rec_disp),
      .sel     (rec_sel)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_OPC;
         cls_q     <= JC_NONE;
         op32_q    <= 1'b0;
         bad_q     <= 1'b0;
         modrm_q   <= '0;
         len_q     <= '0;
         imm_len_q <= '0;
         cnt_q     <= '0;
      end else begin
         unique case (state_q)
            ST_OPC: if (take) begin
               cls_q     <= opc_cls;
               op32_q    <= op32_now;
               bad_q     <= !need_modrm && opc_cls == JC_NONE;
               modrm_q   <= '0;
               len_q     <= LEN_W'(1);
               imm_len_q <= opc_imm_len;
               cnt_q     <= '0;
               if (need_modrm)             state_q <= ST_MODRM;
               else if (opc_imm_len != '0) state_q <= ST_IMM;
               else                        state_q <= ST_OUT;
            end
            ST_MODRM: if (take) begin
               modrm_q <= in_byte;
               cls_q   <= mrm_cls;
               bad_q   <= mrm_bad;
               len_q   <= LEN_W'(2);
               state_q <= ST_OUT;
            end
            ST_IMM: if (take) begin
               cnt_q <= cnt_q + 1'b1;
               if (LEN_W'(cnt_q) == imm_len_q - 1'b1) begin
                  len_q   <= imm_len_q + 1'b1;
                  state_q <= ST_OUT;
               end
            end
            ST_OUT: if (rec_ready) state_q <= ST_OPC;
            default: state_q <= ST_OPC;
         endcase
      end
   end

   assign rec_cls  = cls_q;
   assign rec_op32 = op32_q;
   assign rec_bad  = bad_q;
   assign rec_len  = len_q;
   assign rec_mod  = modrm_q[7:6];
   assign rec_reg  = modrm_q[5:3];
   assign rec_rm   = modrm_q[2:0];
endmodule

// File: rtl/jmpdec_checker.sv
module jmpdec_checker #(
   parameter int DISP_W = 32,
   parameter int LEN_W  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_ready,
   input logic              rec_valid,
   input logic              rec_ready,
   input logic [2:0]        rec_cls,
   input logic              rec_op32,
   input logic [DISP_W-1:0] rec_disp,
   input logic [1:0]        rec_mod,
   input logic [2:0]        rec_reg,
   input logic              rec_bad,
   input logic [LEN_W-1:0]  rec_len
);
   AST_HOLD_OFF_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
      rec_valid |-> !in_ready); // R9

   AST_RECORD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      rec_valid && !rec_ready |=> rec_valid && $stable(rec_disp) && $stable(rec_len)
                                  && $stable(rec_cls)); // R9

   AST_SHORT_LEN_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
      rec_valid && rec_cls == 3'd1 |-> rec_len == LEN_W'(2)
         && (rec_disp[DISP_W-1:7] == '0 || rec_disp[DISP_W-1:7] == '1)); // R2

   AST_NEAR_REL_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      rec_valid && rec_cls == 3'd2 |-> rec_len == (rec_op32 ? LEN_W'(5) : LEN_W'(3))); // R3

   AST_NEAR_IND_REG: assert property (@(posedge clk) disable iff (!rst_n)
      rec_valid && rec_cls == 3'd3 |-> rec_reg == 3'd4 && rec_len == LEN_W'(2)); // R5

   AST_FAR_IND_MEM: assert property (@(posedge clk) disable iff (!rst_n)
      rec_valid && rec_cls == 3'd5 |-> rec_mod != 2'd3 && rec_reg == 3'd5); // R6

   AST_FAR_DIR_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      rec_valid && rec_cls == 3'd4 |-> rec_len == (rec_op32 ? LEN_W'(7) : LEN_W'(5))); // R7

   AST_BAD_NO_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
      rec_valid && rec_bad |-> rec_cls == 3'd0); // R8
endmodule

bind jmp_byte_decoder jmpdec_checker #(.DISP_W(DISP_W), .LEN_W(LEN_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_ready  (in_ready),
   .rec_valid (rec_valid),
   .rec_ready (rec_ready),
   .rec_cls   (rec_cls),
   .rec_op32  (rec_op32),
   .rec_disp  (rec_disp),
   .rec_mod   (rec_mod),
   .rec_reg   (rec_reg),
   .rec_bad   (rec_bad),
   .rec_len   (rec_len)
);

// File: tb/jmp_byte_decoder_tb.sv
module jmp_byte_decoder_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic def_op32 = 1'b1, osz_ovr = 1'b0;
   logic in_valid = 1'b0;
   logic [7:0] in_byte = 8'h00;
   logic rec_ready = 1'b0;

   logic in_ready, rec_valid, rec_op32, rec_bad;
   logic [2:0] rec_cls, rec_reg, rec_rm;
   logic [1:0] rec_mod;
   logic [31:0] rec_disp;
   logic [15:0] rec_sel;
   logic [2:0] rec_len;

   logic w_in_ready, w_rec_valid, w_rec_op32, w_rec_bad;
   logic [2:0] w_rec_cls, w_rec_reg, w_rec_rm, w_rec_len;
   logic [1:0] w_rec_mod;
   logic [39:0] w_rec_disp;
   logic [15:0] w_rec_sel;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   always #10 clk = ~clk; // 50 MHz

   jmp_byte_decoder u_dut (
      .clk(clk), .rst_n(rst_n), .def_op32(def_op32), .osz_ovr(osz_ovr),
      .in_valid(in_valid), .in_byte(in_byte), .in_ready(in_ready),
      .rec_valid(rec_valid), .rec_ready(rec_ready), .rec_cls(rec_cls),
      .rec_op32(rec_op32), .rec_disp(rec_disp), .rec_sel(rec_sel),
      .rec_mod(rec_mod), .rec_reg(rec_reg), .rec_rm(rec_rm),
      .rec_bad(rec_bad), .rec_len(rec_len));

   jmp_byte_decoder #(.DISP_W(40)) u_wide (
      .clk(clk), .rst_n(rst_n), .def_op32(def_op32), .osz_ovr(osz_ovr),
      .in_valid(in_valid), .in_byte(in_byte), .in_ready(w_in_ready),
      .rec_valid(w_rec_valid), .rec_ready(rec_ready), .rec_cls(w_rec_cls),
      .rec_op32(w_rec_op32), .rec_disp(w_rec_disp), .rec_sel(w_rec_sel),
      .rec_mod(w_rec_mod), .rec_reg(w_rec_reg), .rec_rm(w_rec_rm),
      .rec_bad(w_rec_bad), .rec_len(w_rec_len));

   task automatic chk(input string req, input string what,
                      input logic [47:0] act, input logic [47:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic send_byte(input logic [7:0] b);
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1;
      in_byte  = b;
      @(negedge clk);
      in_valid = 1'b0;
      in_byte  = 8'hEA; // junk while idle, must be ignored (R10)
   endtask

   task automatic expect_rec(input string req, input logic [2:0] cls, input logic op32,
                             input logic [31:0] disp, input logic [15:0] sel,
                             input logic [2:0] len, input logic bad,
                             input logic [7:0] modrm);
      int n = 0;
      while (!rec_valid && n < 50) begin
         @(negedge clk);
         n++;
      end
      chk(req, "valid", 48'(rec_valid), 48'(1));
      chk(req, "class", 48'(rec_cls), 48'(cls));
      chk(req, "op32",  48'(rec_op32), 48'(op32));
      chk(req, "disp",  48'(rec_disp), 48'(disp));
      chk(req, "sel",   48'(rec_sel), 48'(sel));
      chk(req, "len",   48'(rec_len), 48'(len));
      chk(req, "bad",   48'(rec_bad), 48'(bad));
      chk(req, "modrm", 48'({rec_mod, rec_reg, rec_rm}), 48'(modrm));
      rec_ready = 1'b1;
      @(negedge clk);
      rec_ready = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1", "in_ready", 48'(in_ready), 48'(1));
      chk("R1", "rec_valid", 48'(rec_valid), 48'(0));
   endtask

   task automatic t_short();
      def_op32 = 1'b1; osz_ovr = 1'b0;
      send_byte(8'hEB); send_byte(8'h85);
      chk("R2", "wide disp", w_rec_disp, 48'hFF_FFFF_FF85);
      expect_rec("R2", 3'd1, 1'b1, 32'hFFFF_FF85, 16'h0, 3'd2, 1'b0, 8'h00);
      send_byte(8'hEB); send_byte(8'h7F);
      expect_rec("R2", 3'd1, 1'b1, 32'h0000_007F, 16'h0, 3'd2, 1'b0, 8'h00);
   endtask

   task automatic t_near();
      def_op32 = 1'b1; osz_ovr = 1'b0;
      send_byte(8'hE9); send_byte(8'h78); send_byte(8'h56); send_byte(8'h34); send_byte(8'h12);
      expect_rec("R3", 3'd2, 1'b1, 32'h1234_5678, 16'h0, 3'd5, 1'b0, 8'h00);
      osz_ovr = 1'b1;
      send_byte(8'hE9); send_byte(8'h00); send_byte(8'h80);
      chk("R3", "wide disp", w_rec_disp, 48'hFF_FFFF_8000);
      expect_rec("R3/R4", 3'd2, 1'b0, 32'hFFFF_8000, 16'h0, 3'd3, 1'b0, 8'h00);
      def_op32 = 1'b0; osz_ovr = 1'b0;
      send_byte(8'hE9); send_byte(8'hFF); send_byte(8'h7F);
      expect_rec("R3/R4", 3'd2, 1'b0, 32'h0000_7FFF, 16'h0, 3'd3, 1'b0, 8'h00);
   endtask

   task automatic t_size_sample();
      def_op32 = 1'b0; osz_ovr = 1'b1;
      send_byte(8'hE9);
      osz_ovr = 1'b0; // R4: change after opcode has no effect
      send_byte(8'h01); send_byte(8'h02); send_byte(8'h03); send_byte(8'h84);
      expect_rec("R4", 3'd2, 1'b1, 32'h8403_0201, 16'h0, 3'd5, 1'b0, 8'h00);
   endtask

   task automatic t_indirect();
      send_byte(8'hFF); send_byte(8'hE0);
      expect_rec("R5", 3'd3, 1'b0, 32'h0, 16'h0, 3'd2, 1'b0, 8'hE0);
      send_byte(8'hFF); send_byte(8'h25);
      expect_rec("R5", 3'd3, 1'b0, 32'h0, 16'h0, 3'd2, 1'b0, 8'h25);
      def_op32 = 1'b1;
      send_byte(8'hFF); send_byte(8'h2B);
      expect_rec("R6", 3'd5, 1'b1, 32'h0, 16'h0, 3'd2, 1'b0, 8'h2B);
   endtask

   task automatic t_far();
      def_op32 = 1'b0; osz_ovr = 1'b0;
      send_byte(8'hEA); send_byte(8'h34); send_byte(8'h12); send_byte(8'h00); send_byte(8'hF0);
      expect_rec("R7", 3'd4, 1'b0, 32'h0000_1234, 16'hF000, 3'd5, 1'b0, 8'h00);
      send_byte(8'hEA); send_byte(8'h00); send_byte(8'h80); send_byte(8'h10); send_byte(8'h00);
      expect_rec("R7", 3'd4, 1'b0, 32'h0000_8000, 16'h0010, 3'd5, 1'b0, 8'h00);
      def_op32 = 1'b1;
      send_byte(8'hEA); send_byte(8'h78); send_byte(8'h56); send_byte(8'h34); send_byte(8'h92);
      send_byte(8'h08); send_byte(8'h00);
      expect_rec("R7", 3'd4, 1'b1, 32'h9234_5678, 16'h0008, 3'd7, 1'b0, 8'h00);
   endtask

   task automatic t_invalid();
      send_byte(8'hFF); send_byte(8'hE8);
      expect_rec("R8", 3'd0, 1'b1, 32'h0, 16'h0, 3'd2, 1'b1, 8'hE8);
      send_byte(8'hFF); send_byte(8'h10);
      expect_rec("R8", 3'd0, 1'b1, 32'h0, 16'h0, 3'd2, 1'b1, 8'h10);
      send_byte(8'h90);
      expect_rec("R8", 3'd0, 1'b1, 32'h0, 16'h0, 3'd1, 1'b1, 8'h00);
   endtask

   task automatic t_backpressure();
      send_byte(8'hEB); send_byte(8'h80);
      in_valid = 1'b1; in_byte = 8'hE9;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         chk("R9", "in_ready low", 48'(in_ready), 48'(0));
         chk("R9", "disp held", 48'(rec_disp), 48'(32'hFFFF_FF80));
      end
      in_valid = 1'b0;
      expect_rec("R9", 3'd1, 1'b1, 32'hFFFF_FF80, 16'h0, 3'd2, 1'b0, 8'h00);
      send_byte(8'hEB); send_byte(8'h05);
      expect_rec("R9/R10", 3'd1, 1'b1, 32'h0000_0005, 16'h0, 3'd2, 1'b0, 8'h00);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_short();
      t_near();
      t_size_sample();
      t_indirect();
      t_far();
      t_invalid();
      t_backpressure();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule